// File: doc/BRIEF.md
# Inter-processor mailbox

The mailbox lets processors pass 64-bit messages to one another over eight channels. It sits on a byte-wide register bus and keeps a message slot for each channel. For each target processor it holds an enable mask, a pending mask and an interrupt line. A sender first stores the message bytes in the channel's slot. It then clears any stale pending bit through the target's clear register and sets the channel bit in the target's enable byte with a read-modify-write. Last, it writes the channel bit to the shared set register. A set write raises the channel's pending bit for every processor whose enable bit for that channel is 1.

The receiver reads its pending byte and takes the message from the slot. It acknowledges through its clear register and then drops the channel's enable bit. The sender polls that enable bit and treats the transfer as finished once the bit reads back 0. A done byte per processor gives the same information with inverted sense.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, all enable bytes, pending bytes and slot bytes are 0, and every interrupt output is 0.
- R2: Byte b of channel i's slot is read/write storage at offset 0x400 + 8*i + b (i 0..7, b 0..7). Offset 0x440 and above are outside the slot region.
- R3: Processor c's enable byte is read/write at offset 4*c, with bit i enabling channel i. Its done byte at 4*c + 2 is read-only and returns the bitwise inverse of the enable byte.
- R4: A write to offset 0x60 sets pending bit i of processor c where data bit i and enable bit i of c are both 1. Every other pending bit keeps its value. A read of 0x60 returns 0.
- R5: A write to offset 0x10 + 16*c clears processor c's pending bits wherever the data holds a 1. Other processors are not affected, and a read of that offset returns 0.
- R6: A read of offset 0x18 + 16*c returns processor c's pending byte. A write to that offset has no effect.
- R7: irq_o[c] is 1 exactly when processor c has any pending bit set. It follows the pending byte in the cycle after the write that changes it.
- R8: Clearing an enable bit leaves the pending bits unchanged.
- R9: Reads of unmapped offsets return 0, and writes to them change no state. rdata_o is 0 whenever re_i is 0.
- R10: A read in the same cycle as a write returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 11 | Byte offset |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_o | output | 4 | One interrupt per processor |

## Verification
A bus read and a bus write can fall in the same cycle. When they target the same register, the read must return the value held before the write. The bench provokes this by raising both strobes on an enable byte in one cycle, and it compares the read data with the value its model held before the write. It repeats this for a slot byte. Random traffic mixes set, clear and enable writes with reads, and a reference model scores the pending bytes and interrupt lines after every write.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int unsigned EN_STRIDE  = 4;
  localparam int unsigned DONE_OFS   = 2;
  localparam int unsigned CLR_BASE   = 'h10;
  localparam int unsigned PEND_BASE  = 'h18;
  localparam int unsigned GRP_STRIDE = 16;
  localparam int unsigned SET_OFS    = 'h60;
  localparam int unsigned SLOT_BASE  = 'h400;

  typedef enum logic [2:0] {
    K_NONE, K_EN, K_DONE, K_CLR, K_PEND, K_SET, K_SLOT
  } reg_kind_e;
endpackage

// File: rtl/mbox_addr_dec.sv
module mbox_addr_dec
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned N_CPU     = 4,
  parameter int unsigned N_CHAN    = 8,
  parameter int unsigned MSG_BYTES = 8,
  localparam int unsigned CPU_W    = (N_CPU > 1) ? $clog2(N_CPU) : 1,
  localparam int unsigned SLOT_W   = $clog2(N_CHAN * MSG_BYTES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [CPU_W-1:0]  cpu_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam int unsigned SLOT_END = SLOT_BASE + N_CHAN * MSG_BYTES;

  always_comb begin
    kind_o = K_NONE;
    cpu_o  = '0;
    slot_o = addr_i[SLOT_W-1:0];
    for (int c = 0; c < N_CPU; c++) begin
      if (addr_i == ADDR_W'(EN_STRIDE * c)) begin
        kind_o = K_EN; cpu_o = CPU_W'(c);
      end
      if (addr_i == ADDR_W'(EN_STRIDE * c + DONE_OFS)) begin
        kind_o = K_DONE; cpu_o = CPU_W'(c);
      end
      if (addr_i == ADDR_W'(CLR_BASE + GRP_STRIDE * c)) begin
        kind_o = K_CLR; cpu_o = CPU_W'(c);
      end
      if (addr_i == ADDR_W'(PEND_BASE + GRP_STRIDE * c)) begin
        kind_o = K_PEND; cpu_o = CPU_W'(c);
      end
    end
    if (addr_i == ADDR_W'(SET_OFS)) kind_o = K_SET;
    if (addr_i >= ADDR_W'(SLOT_BASE) && addr_i < ADDR_W'(SLOT_END)) kind_o = K_SLOT;
  end
endmodule

// File: rtl/mbox_cpu_ctrl.sv
module mbox_cpu_ctrl #(
  parameter int unsigned N_CHAN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic              set_we_i,
  input  logic              clr_we_i,
  input  logic [N_CHAN-1:0] wdata_i,
  output logic [N_CHAN-1:0] en_o,
  output logic [N_CHAN-1:0] pend_o,
  output logic              irq_o
);
  logic [N_CHAN-1:0] en_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_we_i) en_q <= wdata_i;
      if (set_we_i)      pend_q <= pend_q | (wdata_i & en_q);
      else if (clr_we_i) pend_q <= pend_q & ~wdata_i;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = |pend_q;

  a_r4_set_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((pend_o & $past(wdata_i & en_o)) == $past(wdata_i & en_o)));
  a_r4_only_set_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_we_i |=> ((pend_o & ~$past(pend_o)) == '0));
  a_r5_clr_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((pend_o & $past(wdata_i)) == '0));
  a_r3_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_o));
  a_r8_en_keeps_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_we_i && !set_we_i && !clr_we_i) |=> $stable(pend_o));
  a_r7_irq_fall_on_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(clr_we_i));
endmodule

// File: rtl/mbox_msg_store.sv
module mbox_msg_store #(
  parameter int unsigned N_CHAN    = 8,
  parameter int unsigned MSG_BYTES = 8,
  localparam int unsigned DEPTH    = N_CHAN * MSG_BYTES,
  localparam int unsigned SLOT_W   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] idx_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];

  a_r2_slot_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i ##1 (idx_i == $past(idx_i))) |-> (rdata_o == $past(wdata_i)));
  a_r2_slot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i ##1 $stable(idx_i)) |-> $stable(rdata_o));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned N_CPU     = 4,
  parameter int unsigned N_CHAN    = 8,
  parameter int unsigned MSG_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CPU-1:0]  irq_o
);
  localparam int unsigned CPU_W  = (N_CPU > 1) ? $clog2(N_CPU) : 1;
  localparam int unsigned SLOT_W = $clog2(N_CHAN * MSG_BYTES);

  reg_kind_e         kind;
  logic [CPU_W-1:0]  cpu;
  logic [SLOT_W-1:0] slot;
  logic [N_CHAN-1:0] en   [N_CPU];
  logic [N_CHAN-1:0] pend [N_CPU];
  logic [7:0]        slot_rd;
  logic              set_we;

  mbox_addr_dec #(
    .ADDR_W(ADDR_W), .N_CPU(N_CPU), .N_CHAN(N_CHAN), .MSG_BYTES(MSG_BYTES)
  ) i_dec (
    .addr_i(addr_i), .kind_o(kind), .cpu_o(cpu), .slot_o(slot)
  );

  assign set_we = we_i && (kind == K_SET);

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    mbox_cpu_ctrl #(.N_CHAN(N_CHAN)) i_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_we_i (we_i && kind == K_EN  && cpu == CPU_W'(c)),
      .set_we_i(set_we),
      .clr_we_i(we_i && kind == K_CLR && cpu == CPU_W'(c)),
      .wdata_i (wdata_i[N_CHAN-1:0]),
      .en_o    (en[c]),
      .pend_o  (pend[c]),
      .irq_o   (irq_o[c])
    );
  end

  mbox_msg_store #(.N_CHAN(N_CHAN), .MSG_BYTES(MSG_BYTES)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i && kind == K_SLOT),
    .idx_i  (slot),
    .wdata_i(wdata_i[7:0]),
    .rdata_o(slot_rd)
  );

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      unique case (kind)
        K_EN:    rdata_o = DATA_W'(en[cpu]);
        K_DONE:  rdata_o = DATA_W'(~en[cpu]);
        K_PEND:  rdata_o = DATA_W'(pend[cpu]);
        K_SLOT:  rdata_o = DATA_W'(slot_rd);
        default: rdata_o = '0;
      endcase
    end
  end

  a_r9_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> (rdata_o == '0));
endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  rdata;
  logic [3:0]  irq;
  int n_chk = 0, n_fail = 0;

  logic [7:0] m_en [4];
  logic [7:0] m_pend [4];
  logic [7:0] m_slot [64];

  always #4 clk = ~clk;

  ipc_mailbox i_ipc_mailbox (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [10:0] a);
    for (int c = 0; c < 4; c++) begin
      if (a == 11'(4*c))        return m_en[c];
      if (a == 11'(4*c+2))      return ~m_en[c];
      if (a == 11'('h18+16*c))  return m_pend[c];
    end
    if (a >= 11'h400 && a < 11'h440) return m_slot[a - 11'h400];
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [10:0] a);
    for (int c = 0; c < 4; c++) begin
      if (a == 11'(4*c) || a == 11'(4*c+2)) return "R3";
      if (a == 11'('h10+16*c)) return "R5";
      if (a == 11'('h18+16*c)) return "R6";
    end
    if (a == 11'h60) return "R4";
    if (a >= 11'h400 && a < 11'h440) return "R2";
    return "R9";
  endfunction

  task automatic model_wr(input logic [10:0] a, input logic [7:0] d);
    for (int c = 0; c < 4; c++) begin
      if (a == 11'(4*c)) m_en[c] = d;
      if (a == 11'('h10+16*c)) m_pend[c] &= ~d;
    end
    if (a == 11'h60) for (int c = 0; c < 4; c++) m_pend[c] |= d & m_en[c];
    if (a >= 11'h400 && a < 11'h440) m_slot[a - 11'h400] = d;
  endtask

  task automatic chk_irq();
    for (int c = 0; c < 4; c++) chk("R7 irq", {7'd0, irq[c]}, {7'd0, |m_pend[c]});
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
    model_wr(a, d);
    chk_irq();
  endtask

  task automatic rd(input logic [10:0] a);
    @(negedge clk); addr = a; re = 1'b1;
    #1 chk(tag_of(a), rdata, exp_rd(a));
    re = 1'b0;
    #1 chk("R9 idle", rdata, 8'h00);
  endtask

  function automatic logic [10:0] pick(input int unsigned r);
    int unsigned c = (r >> 4) % 4;
    case (r % 8)
      0: return 11'(4*c);
      1: return 11'(4*c+2);
      2: return 11'('h10+16*c);
      3: return 11'('h18+16*c);
      4: return 11'h60;
      5: return 11'('h400 + (r >> 8) % 64);
      6: return 11'('h100 + (r >> 8) % 'h300);
      default: return ((r >> 8) % 2) ? 11'h440 : 11'h61;
    endcase
  endfunction

  initial begin
    #(8*150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned r;
    logic [7:0] t;
    for (int c = 0; c < 4; c++) begin m_en[c] = '0; m_pend[c] = '0; end
    for (int i = 0; i < 64; i++) m_slot[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {4'd0, irq}, 8'h00);
    rd(11'h000); rd(11'h00E); rd(11'h018); rd(11'h048); rd(11'h400); rd(11'h43F);

    // directed send from cpu0 to cpu1 on channel 3
    for (int b = 0; b < 8; b++) wr(11'('h400 + 24 + b), 8'(8'h30 + b));
    wr(11'h020, 8'h08);
    rd(11'h004); t = rdata;
    wr(11'h004, m_en[1] | 8'h08);
    rd(11'h006);
    wr(11'h060, 8'h08);
    rd(11'h028); chk("R4 pend1", m_pend[1], 8'h08);
    rd(11'h018); chk("R4 no en cpu0", m_pend[0], 8'h00);
    for (int b = 0; b < 8; b++) rd(11'('h400 + 24 + b));
    // R8: dropping enable keeps pending
    wr(11'h004, 8'h00); rd(11'h028); chk("R8 pend kept", m_pend[1], 8'h08);
    // R6: write to pending byte ignored
    wr(11'h028, 8'hFF); rd(11'h028);
    // R5: clear affects only cpu1
    wr(11'h000, 8'h08); wr(11'h060, 8'h08);
    wr(11'h020, 8'h08); rd(11'h028); rd(11'h018);
    chk("R5 other cpu", {7'd0, irq[0]}, 8'h01);
    wr(11'h010, 8'hFF); chk("R7 low", {4'd0, irq}, 8'h00);
    // R9 unmapped and boundary
    wr(11'h7FF, 8'hAA); wr(11'h440, 8'h55); wr(11'h061, 8'h0F);
    rd(11'h7FF); rd(11'h440); rd(11'h060); rd(11'h010); rd(11'h43F);
    wr(11'h43F, 8'hC3); rd(11'h43F); rd(11'h400);

    // R10 read during write, enable byte then slot byte
    @(negedge clk); addr = 11'h000; wdata = 8'hA5; we = 1'b1; re = 1'b1;
    #1 chk("R10 en", rdata, m_en[0]);
    @(negedge clk); we = 1'b0; re = 1'b0; model_wr(11'h000, 8'hA5);
    rd(11'h000);
    @(negedge clk); addr = 11'h405; wdata = 8'h5A; we = 1'b1; re = 1'b1;
    #1 chk("R10 slot", rdata, m_slot[5]);
    @(negedge clk); we = 1'b0; re = 1'b0; model_wr(11'h405, 8'h5A);
    rd(11'h405);

    // random traffic
    for (int k = 0; k < 600; k++) begin
      r = $urandom;
      if (r[31]) wr(pick(r), 8'($urandom));
      else rd(pick(r));
    end
    for (int c = 0; c < 4; c++) rd(11'('h18 + 16*c));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule